// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Interrupts

This block is a general-purpose I/O controller whose pins are split across two independent banks, a primary bank and a standby bank. Each bank keeps its own per-pin state: pin enable, direction, output level, rising and falling trigger enables, an interrupt mask bit, a system-management route bit and a sticky trigger status. Software reaches every bit through a byte-wide register port. Bit 5 of the address selects the bank, bits 4..2 select the register, and bits 1..0 select the byte within the register.

Pin inputs are brought into the clock domain by a two-stage synchronizer. Edges are found by comparing the synchronized value with its value one clock earlier. A detected edge of the selected polarity sets the pin's status bit, which stays set until software writes a one to it. A single interrupt line is high whenever any status bit whose mask bit is set is high, in either bank.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: After reset every register bit is 0, every register read returns 0x00, irq_o is 0 and no pin drives.
- R2: Address bit 5 selects the bank (0 primary, 1 standby). Bits 4..2 select the register: 0 enable, 1 direction, 2 level, 3 rising enable, 4 falling enable, 5 interrupt mask, 6 management route, 7 status. Bits 1..0 select the byte. Pin p of a bank sits in byte p/8 at bit p mod 8. Global pins numbered CORE_PINS and above belong to the standby bank as pin (global - CORE_PINS). Bits beyond a bank's pin count read 0 and ignore writes.
- R3: A pin drives pin_oe_o high only when its enable bit is 1 and its direction bit is 0. pin_out_o carries the level register.
- R4: A level-register read returns, for each bit, the synchronized input when direction is 1 and the stored level when direction is 0. An input change shows in the read after two rising clock edges.
- R5: On an enabled input pin with its rising enable set, a 0-to-1 input change sets status on the third rising clock edge after the change. A falling change does not set it when only the rising enable is set.
- R6: With the falling enable set, a 1-to-0 input change sets status the same way. A rising change does not set it when only the falling enable is set.
- R7: With both enables set, both rising and falling changes set status.
- R8: No status bit is set when the pin's trigger enables are both 0, or when its enable bit is 0, or when its direction bit is 0.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: If an edge capture and a write-one-to-clear hit the same status bit in the same cycle, the bit remains set.
- R11: irq_o is high exactly when some status bit in either bank has its mask bit set. Clearing a mask bit drops the interrupt while the status stays set.
- R12: The management-route register is plain read/write storage and has no effect on irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pin_i | input | CORE_PINS+RESUME_PINS | Pin inputs, asynchronous |
| pin_out_o | output | CORE_PINS+RESUME_PINS | Output level per pin |
| pin_oe_o | output | CORE_PINS+RESUME_PINS | Output enable per pin |
| irq_o | output | 1 | Combined edge interrupt |

## Verification
On every cycle the assertions check three things. The interrupt agrees with the masked status of both banks. A status bit only falls in a cycle with a status-register write. A status bit only rises on a pin that had a trigger enable set. The bench's scenarios are needed for the rest: the register map and bank split, the exact three-edge capture latency, the polarity selection per mode, the gating by pin enable and direction, and the collision of a capture with a clear in the same cycle. None of these can be seen from a single cycle's state.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int BANK_BIT  = 5;
  localparam int MAX_BYTES = 4;

  typedef enum logic [2:0] {
    REG_ENABLE = 3'd0,
    REG_DIR    = 3'd1,
    REG_LEVEL  = 3'd2,
    REG_RISE   = 3'd3,
    REG_FALL   = 3'd4,
    REG_MASK   = 3'd5,
    REG_ROUTE  = 3'd6,
    REG_STATUS = 3'd7
  } gpio_reg_e;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int PINS = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] pin_i,
  output logic [PINS-1:0] sync_o,
  output logic [PINS-1:0] rise_o,
  output logic [PINS-1:0] fall_o
);

  logic [PINS-1:0] meta_q, sync_q, prev_q;
  logic [PINS-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = pin_i;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign sync_o = sync_q;
  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  gpio_reg_e         reg_sel_i,
  input  logic [1:0]        byte_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PINS-1:0]   sync_i,
  input  logic [PINS-1:0]   rise_i,
  input  logic [PINS-1:0]   fall_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PINS-1:0]   out_o,
  output logic [PINS-1:0]   oe_o,
  output logic [PINS-1:0]   sts_o,
  output logic [PINS-1:0]   mask_o,
  output logic [PINS-1:0]   trig_o,
  output logic              irq_o
);

  logic [PINS-1:0] en_q, dir_q, lvl_q, ren_q, fen_q, msk_q, rte_q, sts_q;
  logic [PINS-1:0] en_d, dir_d, lvl_d, ren_d, fen_d, msk_d, rte_d, sts_d;
  logic [PINS-1:0] hit, wbit, clr, cap, rd_vec;

  // byte lane decode per pin
  for (genvar i = 0; i < PINS; i++) begin : g_lane
    assign hit[i]  = (byte_sel_i == 2'(i / DATA_W));
    assign wbit[i] = wdata_i[i % DATA_W];
  end

  assign clr = (wr_en_i && reg_sel_i == REG_STATUS) ? (hit & wbit) : '0;
  assign cap = en_q & dir_q & ((rise_i & ren_q) | (fall_i & fen_q));

  always_comb begin
    en_d  = en_q;
    dir_d = dir_q;
    lvl_d = lvl_q;
    ren_d = ren_q;
    fen_d = fen_q;
    msk_d = msk_q;
    rte_d = rte_q;
    if (wr_en_i) begin
      unique case (reg_sel_i)
        REG_ENABLE: en_d  = (en_q  & ~hit) | (wbit & hit);
        REG_DIR:    dir_d = (dir_q & ~hit) | (wbit & hit);
        REG_LEVEL:  lvl_d = (lvl_q & ~hit) | (wbit & hit);
        REG_RISE:   ren_d = (ren_q & ~hit) | (wbit & hit);
        REG_FALL:   fen_d = (fen_q & ~hit) | (wbit & hit);
        REG_MASK:   msk_d = (msk_q & ~hit) | (wbit & hit);
        REG_ROUTE:  rte_d = (rte_q & ~hit) | (wbit & hit);
        default:    ;
      endcase
    end
    // capture wins over a simultaneous clear
    sts_d = (sts_q & ~clr) | cap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      dir_q <= '0;
      lvl_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      msk_q <= '0;
      rte_q <= '0;
      sts_q <= '0;
    end else begin
      en_q  <= en_d;
      dir_q <= dir_d;
      lvl_q <= lvl_d;
      ren_q <= ren_d;
      fen_q <= fen_d;
      msk_q <= msk_d;
      rte_q <= rte_d;
      sts_q <= sts_d;
    end
  end

  always_comb begin
    unique case (reg_sel_i)
      REG_ENABLE: rd_vec = en_q;
      REG_DIR:    rd_vec = dir_q;
      REG_LEVEL:  rd_vec = (dir_q & sync_i) | (~dir_q & lvl_q);
      REG_RISE:   rd_vec = ren_q;
      REG_FALL:   rd_vec = fen_q;
      REG_MASK:   rd_vec = msk_q;
      REG_ROUTE:  rd_vec = rte_q;
      default:    rd_vec = sts_q;
    endcase
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < PINS; i++) begin
      if (hit[i]) rdata_o[i % DATA_W] = rd_vec[i];
    end
  end

  assign out_o  = lvl_q;
  assign oe_o   = en_q & ~dir_q;
  assign sts_o  = sts_q;
  assign mask_o = msk_q;
  assign trig_o = ren_q | fen_q;
  assign irq_o  = |(sts_q & msk_q);

endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
module gpio_edge_irq_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int CORE_PINS   = 10,
  parameter int RESUME_PINS = 6
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  input  logic [CORE_PINS+RESUME_PINS-1:0] pin_i,
  output logic [CORE_PINS+RESUME_PINS-1:0] pin_out_o,
  output logic [CORE_PINS+RESUME_PINS-1:0] pin_oe_o,
  output logic                             irq_o
);

  localparam int TOTAL_PINS = CORE_PINS + RESUME_PINS;
  localparam int NUM_BANKS  = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [TOTAL_PINS-1:0] sync_v, rise_v, fall_v;
  logic [TOTAL_PINS-1:0] all_sts, all_mask, all_trig;
  logic [DATA_W-1:0]     bank_rd  [NUM_BANKS];
  logic [NUM_BANKS-1:0]  bank_irq;
  gpio_reg_e             reg_sel;

  assign reg_sel = gpio_reg_e'(addr_i[4:2]);

  gpio_edge_sync #(.PINS(TOTAL_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .pin_i  (pin_i),
    .sync_o (sync_v),
    .rise_o (rise_v),
    .fall_o (fall_v)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int P  = (b == 0) ? CORE_PINS : RESUME_PINS;
    localparam int LO = (b == 0) ? 0 : CORE_PINS;
    logic bank_wr;
    assign bank_wr = wr_en_i && (addr_i[BANK_BIT] == 1'(b));

    gpio_edge_bank #(.PINS(P)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_sync_q),
      .wr_en_i    (bank_wr),
      .reg_sel_i  (reg_sel),
      .byte_sel_i (addr_i[1:0]),
      .wdata_i    (wdata_i),
      .sync_i     (sync_v[LO +: P]),
      .rise_i     (rise_v[LO +: P]),
      .fall_i     (fall_v[LO +: P]),
      .rdata_o    (bank_rd[b]),
      .out_o      (pin_out_o[LO +: P]),
      .oe_o       (pin_oe_o[LO +: P]),
      .sts_o      (all_sts[LO +: P]),
      .mask_o     (all_mask[LO +: P]),
      .trig_o     (all_trig[LO +: P]),
      .irq_o      (bank_irq[b])
    );
  end

  assign rdata_o = bank_rd[addr_i[BANK_BIT]];
  assign irq_o   = |bank_irq;

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int PINS = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [5:0]      addr_i,
  input logic            irq_i,
  input logic [PINS-1:0] sts_i,
  input logic [PINS-1:0] mask_i,
  input logic [PINS-1:0] trig_i
);

  // R11: interrupt agrees with masked status of both banks
  assert_irq_matches_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == (|(sts_i & mask_i)));

  // R11: a raised interrupt always has a status source
  assert_irq_has_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (sts_i != '0));

  // R9: without a status write, no status bit falls
  assert_status_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i[4:2] == 3'd7) |=> (($past(sts_i) & ~sts_i) == '0));

  // R8: a status bit only rises where a trigger enable was set
  assert_no_spurious_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_i & ~$past(sts_i) & ~$past(trig_i)) == '0));

endmodule

bind gpio_edge_irq_ctrl gpio_edge_irq_chk #(.PINS(CORE_PINS + RESUME_PINS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_sync_q),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .irq_i   (irq_o),
  .sts_i   (all_sts),
  .mask_i  (all_mask),
  .trig_i  (all_trig)
);

// File: tb/test_gpio_edge_irq_ctrl.sv
module test_gpio_edge_irq_ctrl;

  localparam int CORE   = 10;
  localparam int RESUME = 6;
  localparam int TOTAL  = CORE + RESUME;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en;
  logic [5:0]       addr;
  logic [7:0]       wdata;
  logic [7:0]       rdata;
  logic [TOTAL-1:0] pin_in;
  logic [TOTAL-1:0] pin_out;
  logic [TOTAL-1:0] pin_oe;
  logic             irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_edge_irq_ctrl #(.CORE_PINS(CORE), .RESUME_PINS(RESUME)) i_gpio_edge_irq_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .pin_i     (pin_in),
    .pin_out_o (pin_out),
    .pin_oe_o  (pin_oe),
    .irq_o     (irq)
  );

  typedef struct packed {
    logic       wr;
    logic [5:0] a;
    logic [7:0] d;
  } vec_t;

  // write entries store d; read entries expect d
  localparam vec_t VECS [16] = '{
    '{1'b1, 6'h04, 8'hFF}, '{1'b0, 6'h04, 8'hFF},
    '{1'b1, 6'h05, 8'hFF}, '{1'b0, 6'h05, 8'h03},
    '{1'b1, 6'h24, 8'hFF}, '{1'b0, 6'h24, 8'h3F},
    '{1'b1, 6'h06, 8'hFF}, '{1'b0, 6'h06, 8'h00},
    '{1'b1, 6'h18, 8'hA5}, '{1'b0, 6'h18, 8'hA5},
    '{1'b0, 6'h38, 8'h00}, '{1'b1, 6'h3C, 8'hFF},
    '{1'b0, 6'h3C, 8'h00}, '{1'b1, 6'h2D, 8'hFF},
    '{1'b0, 6'h2D, 8'h00}, '{1'b0, 6'h24, 8'h3F}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [7:0] exp);
    addr = a;
    #0.5;
    chk(tag, rdata, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n  = 1'b0;
    wr_en  = 1'b0;
    addr   = '0;
    wdata  = '0;
    pin_in = '0;
    do_reset();

    // R1: reset state
    chk("R1 irq", irq, 0);
    chk("R1 oe", pin_oe, 0);
    rd_chk("R1 dir", 6'h04, 8'h00);
    rd_chk("R1 status", 6'h1C, 8'h00);
    rd_chk("R1 resume level", 6'h28, 8'h00);

    // R2, R12: register map table walk
    foreach (VECS[k]) begin
      if (VECS[k].wr) wr(VECS[k].a, VECS[k].d);
      else if (VECS[k].a[4:2] == 3'd6) rd_chk("R12 route", VECS[k].a, VECS[k].d);
      else rd_chk("R2 map", VECS[k].a, VECS[k].d);
    end
    chk("R12 no irq from route", irq, 0);
    do_reset();

    // R3: drive control
    wr(6'h00, 8'hFF);
    wr(6'h04, 8'hF0);
    wr(6'h08, 8'h05);
    chk("R3 oe", pin_oe[7:0], 8'h0F);
    chk("R3 out", pin_out[7:0], 8'h05);

    // R4: level read mixes stored level and synchronized input
    pin_in[7:4] = 4'hA;
    wait_cyc(1);
    rd_chk("R4 before sync", 6'h08, 8'h05);
    wait_cyc(1);
    rd_chk("R4 after sync", 6'h08, 8'hA5);
    wait_cyc(3);
    rd_chk("R8 no trigger enable", 6'h1C, 8'h00);

    // R5: rising edge on core pin 4
    wr(6'h0C, 8'h10);
    pin_in[4] = 1'b1;
    wait_cyc(2);
    rd_chk("R5 latency", 6'h1C, 8'h00);
    wait_cyc(1);
    rd_chk("R5 captured", 6'h1C, 8'h10);
    chk("R11 masked", irq, 0);
    wr(6'h14, 8'h10);
    chk("R11 unmasked", irq, 1);
    wr(6'h14, 8'h00);
    chk("R11 remask irq", irq, 0);
    rd_chk("R11 status kept", 6'h1C, 8'h10);
    wr(6'h14, 8'h10);
    wr(6'h1C, 8'h00);
    rd_chk("R9 zero write", 6'h1C, 8'h10);
    wr(6'h1C, 8'h10);
    rd_chk("R9 clear", 6'h1C, 8'h00);
    chk("R9 irq low", irq, 0);
    pin_in[4] = 1'b0;
    wait_cyc(4);
    rd_chk("R5 falling ignored", 6'h1C, 8'h00);

    // R6: falling only
    wr(6'h0C, 8'h00);
    wr(6'h10, 8'h10);
    pin_in[4] = 1'b1;
    wait_cyc(4);
    rd_chk("R6 rising ignored", 6'h1C, 8'h00);
    pin_in[4] = 1'b0;
    wait_cyc(3);
    rd_chk("R6 captured", 6'h1C, 8'h10);
    wr(6'h1C, 8'h10);

    // R7: both edges
    wr(6'h0C, 8'h10);
    pin_in[4] = 1'b1;
    wait_cyc(3);
    rd_chk("R7 rise", 6'h1C, 8'h10);
    wr(6'h1C, 8'h10);
    pin_in[4] = 1'b0;
    wait_cyc(3);
    rd_chk("R7 fall", 6'h1C, 8'h10);
    wr(6'h1C, 8'h10);

    // R10: capture and clear in the same cycle
    pin_in[4] = 1'b1;
    wait_cyc(4);
    pin_in[4] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    addr  = 6'h1C;
    wdata = 8'h10;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd_chk("R10 collision", 6'h1C, 8'h10);
    wr(6'h1C, 8'h10);
    rd_chk("R10 later clear", 6'h1C, 8'h00);
    wr(6'h14, 8'h00);

    // R8: standby pin 0 (global pin 10) not enabled
    wr(6'h24, 8'h01);
    wr(6'h2C, 8'h01);
    pin_in[CORE] = 1'b1;
    wait_cyc(4);
    rd_chk("R8 pin disabled", 6'h3C, 8'h00);
    wr(6'h20, 8'h01);
    pin_in[CORE] = 1'b0;
    wait_cyc(4);
    pin_in[CORE] = 1'b1;
    wait_cyc(3);
    rd_chk("R2 standby status", 6'h3C, 8'h01);
    rd_chk("R2 primary untouched", 6'h1C, 8'h00);
    wr(6'h34, 8'h01);
    chk("R11 standby irq", irq, 1);
    wr(6'h3C, 8'h01);
    chk("R11 standby cleared", irq, 0);

    // R8: output-direction pin ignores edges
    wr(6'h24, 8'h00);
    pin_in[CORE] = 1'b0;
    wait_cyc(4);
    pin_in[CORE] = 1'b1;
    wait_cyc(4);
    rd_chk("R8 output pin", 6'h3C, 8'h00);

    finish_run();
  end

endmodule